// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block gathers 32 interrupt inputs and presents one active-high request line to a processor. Each input has its own mode word and vector word. The mode word selects the trigger type and a 3-bit priority. The vector word holds the value that software receives when that input is serviced. Inputs can be enabled and disabled one at a time, and edge events that have been latched can be dropped, through command words that act only on the bits written as 1.

Software services the request by reading the vector address. That read is also the acknowledge. It returns the vector of the best enabled pending input, and it pushes that input's priority and number onto a nesting stack of eight entries. While the stack is not empty, only a strictly higher priority can raise the request again. A write to the end-of-interrupt address pops one level and ignores the data. When no input qualifies, the read returns a programmable spurious value and the stack is left unchanged. A protect bit turns the vector read into a read with no side effects, for use by debuggers.

Top module: `vec_intc`

## Requirements
- R1: After reset, irqOut is 0, and every mode word, vector word, the spurious word, the enable mask, the pending word, the status word and the protect bit read 0. A vector read returns 0.
- R2: Mode word i (address i, i from 0 to 31) holds the trigger type in bits [1:0] and the priority in bits [6:4]. The trigger codes are 0 level-high, 1 rising edge, 2 level-low and 3 falling edge. Vector word i sits at address 32+i. An edge-mode input latches pending on its edge. A level-mode input is pending while its input is active.
- R3: Active-low codes (2 and 3) take effect only on inputs 0, 30 and 31. On any other input, code 2 acts as level-high and code 3 acts as rising edge. The mode word still reads back the value written.
- R4: A write to 0x44 sets enable bits, a write to 0x45 clears enable bits, and a write to 0x46 drops latched edge events. Each acts only where a data bit is 1. The enable mask reads at 0x43 and the pending word (one bit per input, before enable) reads at 0x42.
- R5: Among enabled pending inputs, the highest priority wins. On equal priority, the lowest input number wins.
- R6: irqOut is 1 exactly when a winner exists and either the stack is empty or the winner's priority is strictly above the priority on top of the stack.
- R7: A read of 0x40 while irqOut is 1 returns the winner's vector word, pushes the winner, and drops the winner's latched edge event. A level input stays pending.
- R8: A read of 0x40 while irqOut is 0 returns the spurious word (read/write at 0x48) and leaves the stack unchanged.
- R9: The status word at 0x41 returns the input number on top of the stack, or 0 when the stack is empty.
- R10: A write to 0x47 pops one level whatever the data. On an empty stack it has no effect, so eight such writes always leave the stack empty.
- R11: While the protect bit (0x49, bit 0) is 1, a vector read returns the same data as usual but pushes nothing and clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIn | input | 32 | Interrupt inputs, registered once on entry |
| addrIn | input | 8 | Word address |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe (needed for the acknowledging vector read) |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, combinational from addrIn |
| irqOut | output | 1 | Processor interrupt request, active high |

## Verification
On every cycle, the assertions check the stack depth bound, the strict rise of priority through the nested stack, push and pop on acknowledge and end-of-interrupt, that the winner is enabled and pending, and that enable and pending-clear commands take effect. The bench scenarios cover the behaviour that depends on history: edge capture and demotion on internal inputs, tie breaking, a three-level nesting unwound by eight end-of-interrupt writes, the spurious return and the protect read. Random rounds compare vector, status and request results against a priority model kept in the bench.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;
  localparam int unsigned NUM_SRC    = 32;
  localparam int unsigned SRC_W      = $clog2(NUM_SRC);
  localparam int unsigned PRIO_W     = 3;
  localparam int unsigned NEST_DEPTH = 1 << PRIO_W;
  localparam int unsigned PTR_W      = $clog2(NEST_DEPTH);
  localparam int unsigned DEPTH_W    = $clog2(NEST_DEPTH + 1);
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned ADDR_W     = 8;

  localparam int unsigned MODE_TRIG_LSB = 0;
  localparam int unsigned MODE_PRIO_LSB = 4;

  localparam logic [ADDR_W-1:0] VEC_BASE = ADDR_W'(NUM_SRC);
  localparam logic [ADDR_W-1:0] VEC_END  = ADDR_W'(2 * NUM_SRC);
  localparam logic [ADDR_W-1:0] A_VECTOR = 8'h40;
  localparam logic [ADDR_W-1:0] A_STATUS = 8'h41;
  localparam logic [ADDR_W-1:0] A_PEND   = 8'h42;
  localparam logic [ADDR_W-1:0] A_ENMASK = 8'h43;
  localparam logic [ADDR_W-1:0] A_ENSET  = 8'h44;
  localparam logic [ADDR_W-1:0] A_ENCLR  = 8'h45;
  localparam logic [ADDR_W-1:0] A_PCLR   = 8'h46;
  localparam logic [ADDR_W-1:0] A_EOI    = 8'h47;
  localparam logic [ADDR_W-1:0] A_SPUR   = 8'h48;
  localparam logic [ADDR_W-1:0] A_PROT   = 8'h49;

  typedef enum logic [1:0] {
    TRIG_HIGH = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_LOW  = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;

  typedef struct packed {
    logic             modeWr;
    logic             vecWr;
    logic             enSet;
    logic             enClr;
    logic             pendClr;
    logic             spurWr;
    logic             protWr;
    logic             ack;
    logic             eoi;
    logic [SRC_W-1:0] idx;
  } strobe_t;
endpackage

// File: rtl/vec_intc_ctrl.sv
module vec_intc_ctrl
  import vec_intc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic              protEn,
  input  logic              winValid,
  input  logic [SRC_W-1:0]  winSrc,
  input  logic [PRIO_W-1:0] winPrio,
  output strobe_t           stbOut,
  output logic              irqReq,
  output logic              curValid,
  output logic [SRC_W-1:0]  curSrc
);
  logic [PRIO_W-1:0]  prioStk [NEST_DEPTH];
  logic [SRC_W-1:0]   srcStk  [NEST_DEPTH];
  logic [DEPTH_W-1:0] depth;
  logic [PTR_W-1:0]   topIdx;
  logic [PTR_W-1:0]   pushIdx;
  logic [PRIO_W-1:0]  topPrio;
  logic               stackEmpty;
  logic               rdVector;

  assign stackEmpty = (depth == '0);
  assign topIdx     = PTR_W'(depth - 1'b1);
  assign pushIdx    = PTR_W'(depth);
  assign topPrio    = prioStk[topIdx];
  assign irqReq     = winValid && (stackEmpty || (winPrio > topPrio));
  assign curValid   = !stackEmpty;
  assign curSrc     = srcStk[topIdx];
  assign rdVector   = rdEn && !wrEn && (addrIn == A_VECTOR);

  always_comb begin
    stbOut         = '0;
    stbOut.idx     = addrIn[SRC_W-1:0];
    stbOut.modeWr  = wrEn && (addrIn < VEC_BASE);
    stbOut.vecWr   = wrEn && (addrIn >= VEC_BASE) && (addrIn < VEC_END);
    stbOut.enSet   = wrEn && (addrIn == A_ENSET);
    stbOut.enClr   = wrEn && (addrIn == A_ENCLR);
    stbOut.pendClr = wrEn && (addrIn == A_PCLR);
    stbOut.spurWr  = wrEn && (addrIn == A_SPUR);
    stbOut.protWr  = wrEn && (addrIn == A_PROT);
    stbOut.eoi     = wrEn && (addrIn == A_EOI) && !stackEmpty;
    stbOut.ack     = rdVector && irqReq && !protEn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      depth <= '0;
      for (int i = 0; i < NEST_DEPTH; i++) begin
        prioStk[i] <= '0;
        srcStk[i]  <= '0;
      end
    end else if (stbOut.ack) begin
      prioStk[pushIdx] <= winPrio;
      srcStk[pushIdx]  <= winSrc;
      depth            <= depth + 1'b1;
    end else if (stbOut.eoi) begin
      depth <= depth - 1'b1;
    end
  end

  p_depth_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    depth <= DEPTH_W'(NEST_DEPTH));

  p_nest_order_r6: assert property (@(posedge clk) disable iff (!rstN)
    (depth >= DEPTH_W'(2)) |-> (prioStk[topIdx] > prioStk[PTR_W'(topIdx - 1'b1)]));

  p_push_r7: assert property (@(posedge clk) disable iff (!rstN)
    stbOut.ack |=> (depth == $past(depth) + 1'b1));

  p_pop_r10: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (addrIn == A_EOI) && (depth != '0)) |=> (depth == $past(depth) - 1'b1));

  p_spurious_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (rdVector && !winValid && !wrEn) |=> $stable(depth));
endmodule

// File: rtl/vec_intc_dp.sv
module vec_intc_dp
  import vec_intc_pkg::*;
#(
  parameter logic [NUM_SRC-1:0] EXT_MASK = 32'hC000_0001
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [ADDR_W-1:0]  addrIn,
  input  logic [DATA_W-1:0]  wrData,
  input  strobe_t            stb,
  input  logic               irqReq,
  input  logic               curValid,
  input  logic [SRC_W-1:0]   curSrc,
  output logic [DATA_W-1:0]  rdData,
  output logic               protEn,
  output logic               winValid,
  output logic [SRC_W-1:0]   winSrc,
  output logic [PRIO_W-1:0]  winPrio
);
  trig_e              trigQ [NUM_SRC];
  logic [PRIO_W-1:0]  prioQ [NUM_SRC];
  logic [DATA_W-1:0]  vecQ  [NUM_SRC];
  logic [NUM_SRC-1:0] enMask;
  logic [NUM_SRC-1:0] edgePend;
  logic [NUM_SRC-1:0] srcQ;
  logic [NUM_SRC-1:0] srcPrev;
  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] isEdgeV;
  logic [NUM_SRC-1:0] edgeHitV;
  logic [NUM_SRC-1:0] cand;
  logic [DATA_W-1:0]  spurVec;
  logic               protQ;
  logic [NUM_SRC-1:0] wrMask;

  assign wrMask = wrData[NUM_SRC-1:0];
  assign protEn = protQ;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic activeLow;
    logic lvlAct;
    logic edgeAct;
    if (EXT_MASK[g]) begin : g_ext
      assign activeLow = (trigQ[g] == TRIG_LOW) || (trigQ[g] == TRIG_FALL);
    end else begin : g_int
      assign activeLow = 1'b0;
    end
    assign isEdgeV[g]  = (trigQ[g] == TRIG_RISE) || (trigQ[g] == TRIG_FALL);
    assign lvlAct      = activeLow ? ~srcQ[g] : srcQ[g];
    assign edgeAct     = activeLow ? (srcPrev[g] & ~srcQ[g]) : (srcQ[g] & ~srcPrev[g]);
    assign edgeHitV[g] = isEdgeV[g] & edgeAct;
    assign pend[g]     = isEdgeV[g] ? edgePend[g] : lvlAct;
  end

  assign cand = pend & enMask;

  always_comb begin
    winValid = 1'b0;
    winSrc   = '0;
    winPrio  = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (cand[i] && (!winValid || (prioQ[i] >= winPrio))) begin
        winValid = 1'b1;
        winSrc   = SRC_W'(i);
        winPrio  = prioQ[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcQ     <= '0;
      srcPrev  <= '0;
      enMask   <= '0;
      edgePend <= '0;
      spurVec  <= '0;
      protQ    <= 1'b0;
      for (int i = 0; i < NUM_SRC; i++) begin
        trigQ[i] <= TRIG_HIGH;
        prioQ[i] <= '0;
        vecQ[i]  <= '0;
      end
    end else begin
      srcQ    <= srcIn;
      srcPrev <= srcQ;
      if (stb.enSet) enMask <= enMask | wrMask;
      if (stb.enClr) enMask <= enMask & ~wrMask;
      if (stb.spurWr) spurVec <= wrData;
      if (stb.protWr) protQ <= wrData[0];
      for (int i = 0; i < NUM_SRC; i++) begin
        if (stb.modeWr && (stb.idx == SRC_W'(i))) begin
          trigQ[i] <= trig_e'(wrData[MODE_TRIG_LSB +: 2]);
          prioQ[i] <= wrData[MODE_PRIO_LSB +: PRIO_W];
        end
        if (stb.vecWr && (stb.idx == SRC_W'(i))) vecQ[i] <= wrData;
        if (edgeHitV[i]) edgePend[i] <= 1'b1;
        else if (!isEdgeV[i] || (stb.pendClr && wrMask[i]) ||
                 (stb.ack && (winSrc == SRC_W'(i))))
          edgePend[i] <= 1'b0;
      end
    end
  end

  always_comb begin
    rdData = '0;
    if (addrIn < VEC_BASE) begin
      rdData[MODE_TRIG_LSB +: 2]      = trigQ[stb.idx];
      rdData[MODE_PRIO_LSB +: PRIO_W] = prioQ[stb.idx];
    end else if (addrIn < VEC_END) begin
      rdData = vecQ[stb.idx];
    end else begin
      case (addrIn)
        A_VECTOR: rdData = irqReq ? vecQ[winSrc] : spurVec;
        A_STATUS: rdData[SRC_W-1:0] = curValid ? curSrc : '0;
        A_PEND:   rdData[NUM_SRC-1:0] = pend;
        A_ENMASK: rdData[NUM_SRC-1:0] = enMask;
        A_SPUR:   rdData = spurVec;
        A_PROT:   rdData[0] = protQ;
        default:  rdData = '0;
      endcase
    end
  end

  p_win_eligible_r5: assert property (@(posedge clk) disable iff (!rstN)
    winValid |-> (enMask[winSrc] && pend[winSrc]));

  p_ack_edge_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ack && isEdgeV[winSrc] && !edgeHitV[winSrc]) |=> !edgePend[$past(winSrc)]);

  p_pend_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.pendClr |=> ((edgePend & $past(wrMask) & ~$past(edgeHitV)) == '0));

  p_enable_set_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.enSet |=> ((enMask & $past(wrMask)) == $past(wrMask)));
endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vec_intc_pkg::*;
#(
  parameter logic [NUM_SRC-1:0] EXT_MASK = 32'hC000_0001
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [ADDR_W-1:0]  addrIn,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut
);
  strobe_t           stb;
  logic              protEn;
  logic              winValid;
  logic [SRC_W-1:0]  winSrc;
  logic [PRIO_W-1:0] winPrio;
  logic              curValid;
  logic [SRC_W-1:0]  curSrc;

  vec_intc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .wrEn(wrEn), .rdEn(rdEn),
    .protEn(protEn), .winValid(winValid), .winSrc(winSrc), .winPrio(winPrio),
    .stbOut(stb), .irqReq(irqOut), .curValid(curValid), .curSrc(curSrc)
  );

  vec_intc_dp #(.EXT_MASK(EXT_MASK)) u_dp (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .addrIn(addrIn), .wrData(wrData),
    .stb(stb), .irqReq(irqOut), .curValid(curValid), .curSrc(curSrc),
    .rdData(rdData), .protEn(protEn), .winValid(winValid), .winSrc(winSrc),
    .winPrio(winPrio)
  );
endmodule

// File: tb/vec_intc_tb.sv
module vec_intc_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] srcIn = '0;
  logic [7:0]  addrIn = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irqOut;

  int nChk = 0;
  int nBad = 0;
  bit done = 0;

  logic [31:0] vecM  [32];
  logic [2:0]  prioM [32];
  logic [31:0] spurM;

  always #2 clk = ~clk;

  vec_intc u_dut (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .addrIn(addrIn), .wrEn(wrEn),
    .rdEn(rdEn), .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addrIn = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addrIn = a; rdEn = 1'b1;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic rdChk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    busRd(a, v);
    chk(req, v, exp);
  endtask

  task automatic irqChk(input string req, input logic exp);
    @(negedge clk);
    #1 chk(req, {31'd0, irqOut}, {31'd0, exp});
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setVec(input int s, input logic [31:0] v);
    vecM[s] = v;
    busWr(8'(32 + s), v);
  endtask

  task automatic isolate();
    busWr(8'h45, 32'hFFFF_FFFF);
    busWr(8'h46, 32'hFFFF_FFFF);
  endtask

  function automatic int expWinner(input logic [31:0] cand);
    int w = -1;
    for (int i = 0; i < 32; i++)
      if (cand[i] && (w < 0 || prioM[i] > prioM[w])) w = i;
    return w;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++; nChk++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd1234));
    waitCyc(3);
    rstN = 1'b1;
    @(negedge clk);
    #1 chk("R1 irq", {31'd0, irqOut}, 32'd0);
    rdChk("R1 mode7", 8'd7, 32'd0);
    rdChk("R1 vec12", 8'd44, 32'd0);
    rdChk("R1 spur", 8'h48, 32'd0);
    rdChk("R1 enmask", 8'h43, 32'd0);
    rdChk("R1 pend", 8'h42, 32'd0);
    rdChk("R1 status", 8'h41, 32'd0);
    rdChk("R1 prot", 8'h49, 32'd0);
    rdChk("R1 vector", 8'h40, 32'd0);

    spurM = 32'h5A5A_0000;
    busWr(8'h48, spurM);
    rdChk("R8 spur readback", 8'h48, spurM);

    // R2/R7 rising edge on internal input 5
    setVec(5, 32'h1000_0005);
    busWr(8'd5, 32'h21);
    busWr(8'h44, 32'h20);
    srcIn[5] = 1'b1; waitCyc(3);
    rdChk("R2 rise pend", 8'h42, 32'h20);
    irqChk("R6 irq rise", 1'b1);
    rdChk("R7 ack vec5", 8'h40, vecM[5]);
    rdChk("R9 status 5", 8'h41, 32'd5);
    rdChk("R7 edge cleared", 8'h42, 32'd0);
    irqChk("R6 irq after ack", 1'b0);
    busWr(8'h47, 32'd0);
    rdChk("R10 status after eoi", 8'h41, 32'd0);
    srcIn[5] = 1'b0;
    isolate();

    // R2 level-high stays pending
    setVec(12, 32'h1000_000C);
    busWr(8'd12, 32'h30);
    busWr(8'h44, 32'h1000);
    srcIn[12] = 1'b1; waitCyc(2);
    rdChk("R7 level vec12", 8'h40, vecM[12]);
    rdChk("R7 level still pending", 8'h42, 32'h1000);
    busWr(8'h47, 32'd0);
    irqChk("R2 level reasserts", 1'b1);
    rdChk("R7 level vec12 again", 8'h40, vecM[12]);
    busWr(8'h47, 32'd0);
    srcIn[12] = 1'b0; waitCyc(2);
    irqChk("R2 level released", 1'b0);
    isolate();

    // R2 level-low on external input 30
    busWr(8'd30, 32'h12);
    waitCyc(2);
    busRd(8'h42, v); chk("R2 level-low pend", v & 32'h4000_0000, 32'h4000_0000);
    srcIn[30] = 1'b1; waitCyc(2);
    busRd(8'h42, v); chk("R2 level-low idle", v & 32'h4000_0000, 32'd0);
    busWr(8'd30, 32'h0);
    srcIn[30] = 1'b0;

    // R2 falling edge on external input 31
    setVec(31, 32'h1000_001F);
    srcIn[31] = 1'b1; waitCyc(2);
    busWr(8'd31, 32'h13);
    busWr(8'h44, 32'h8000_0000);
    srcIn[31] = 1'b0; waitCyc(3);
    rdChk("R2 fall pend", 8'h42, 32'h8000_0000);
    rdChk("R7 ack vec31", 8'h40, vecM[31]);
    rdChk("R7 fall cleared", 8'h42, 32'd0);
    busWr(8'h47, 32'd0);
    busWr(8'd31, 32'h0);
    isolate();

    // R3 demotion on internal inputs 6 and 7
    busWr(8'd6, 32'h12);
    rdChk("R3 mode readback", 8'd6, 32'h12);
    waitCyc(2);
    busRd(8'h42, v); chk("R3 low acts high idle", v & 32'h40, 32'd0);
    srcIn[6] = 1'b1; waitCyc(2);
    busRd(8'h42, v); chk("R3 low acts high active", v & 32'h40, 32'h40);
    busWr(8'd7, 32'h13);
    srcIn[7] = 1'b1; waitCyc(3);
    busRd(8'h42, v); chk("R3 fall acts rise", v & 32'h80, 32'h80);
    srcIn[7] = 1'b0;
    busWr(8'h46, 32'h100);
    busRd(8'h42, v); chk("R4 clear zero bit no effect", v & 32'h80, 32'h80);
    busWr(8'h46, 32'h80);
    busRd(8'h42, v); chk("R4 clear pending", v & 32'h80, 32'd0);
    srcIn[6] = 1'b0;
    busWr(8'd6, 32'h0);
    busWr(8'd7, 32'h0);

    // R4 enable set/clear
    busWr(8'h44, 32'hF0);
    rdChk("R4 enset", 8'h43, 32'hF0);
    busWr(8'h44, 32'h0);
    rdChk("R4 enset zero", 8'h43, 32'hF0);
    busWr(8'h45, 32'h30);
    rdChk("R4 enclr", 8'h43, 32'hC0);
    busWr(8'h45, 32'h0);
    rdChk("R4 enclr zero", 8'h43, 32'hC0);
    isolate();
    rdChk("R4 disable all", 8'h43, 32'd0);

    // R5 tie and priority
    setVec(3, 32'h1000_0003);
    setVec(9, 32'h1000_0009);
    setVec(20, 32'h1000_0014);
    busWr(8'd3, 32'h40);
    busWr(8'd9, 32'h40);
    busWr(8'h44, 32'h208);
    srcIn[3] = 1'b1; srcIn[9] = 1'b1; waitCyc(2);
    rdChk("R5 tie lowest", 8'h40, vecM[3]);
    busWr(8'h47, 32'd0);
    busWr(8'd9, 32'h50);
    rdChk("R5 higher prio", 8'h40, vecM[9]);
    busWr(8'h47, 32'd0);

    // R6/R9/R10 nesting
    busWr(8'd3, 32'h10);
    busWr(8'd9, 32'h10);
    busWr(8'd20, 32'h60);
    busWr(8'h44, 32'h0010_0208);
    rdChk("R7 nest lvl1", 8'h40, vecM[3]);
    rdChk("R9 status 3", 8'h41, 32'd3);
    irqChk("R6 equal prio blocked", 1'b0);
    rdChk("R8 blocked read spurious", 8'h40, spurM);
    rdChk("R8 no push", 8'h41, 32'd3);
    busWr(8'd9, 32'h50);
    irqChk("R6 higher preempts", 1'b1);
    rdChk("R7 nest lvl2", 8'h40, vecM[9]);
    rdChk("R9 status 9", 8'h41, 32'd9);
    srcIn[20] = 1'b1; waitCyc(2);
    rdChk("R7 nest lvl3", 8'h40, vecM[20]);
    rdChk("R9 status 20", 8'h41, 32'd20);
    irqChk("R6 top blocks", 1'b0);
    busWr(8'h47, 32'hFFFF_FFFF);
    rdChk("R10 data ignored pop", 8'h41, 32'd9);
    busWr(8'h47, 32'd0);
    rdChk("R10 pop to 3", 8'h41, 32'd3);
    for (int k = 0; k < 6; k++) busWr(8'h47, 32'd0);
    rdChk("R10 eight eoi idle", 8'h41, 32'd0);
    irqChk("R6 empty stack request", 1'b1);
    srcIn = '0; waitCyc(2);
    irqChk("R6 no pending", 1'b0);
    isolate();

    // R8 spurious
    rdChk("R8 spurious", 8'h40, spurM);
    rdChk("R8 status zero", 8'h41, 32'd0);

    // R11 protect
    busWr(8'h49, 32'h1);
    rdChk("R11 prot readback", 8'h49, 32'h1);
    busWr(8'h44, 32'h20);
    srcIn[5] = 1'b1; waitCyc(3);
    rdChk("R11 read one", 8'h40, vecM[5]);
    rdChk("R11 read two", 8'h40, vecM[5]);
    rdChk("R11 no push", 8'h41, 32'd0);
    rdChk("R11 no clear", 8'h42, 32'h20);
    busWr(8'h49, 32'h0);
    rdChk("R11 normal ack", 8'h40, vecM[5]);
    rdChk("R11 pushed", 8'h41, 32'd5);
    busWr(8'h47, 32'd0);
    srcIn[5] = 1'b0;
    isolate();

    // random rounds, all level-high
    for (int s = 0; s < 32; s++) setVec(s, $urandom);
    for (int it = 0; it < 24; it++) begin
      logic [31:0] en;
      logic [31:0] pat;
      int w;
      for (int s = 0; s < 32; s++) begin
        prioM[s] = 3'($urandom % 8);
        busWr(8'(s), {25'd0, prioM[s], 4'd0});
      end
      en = $urandom; pat = $urandom;
      if (it == 0) pat = 32'd0;
      busWr(8'h45, 32'hFFFF_FFFF);
      busWr(8'h44, en);
      srcIn = pat; waitCyc(3);
      w = expWinner(en & pat);
      irqChk("R6 random irq", (w >= 0));
      rdChk("R5 random vector", 8'h40, (w >= 0) ? vecM[w] : spurM);
      if (w >= 0) begin
        rdChk("R9 random status", 8'h41, 32'(w));
        irqChk("R6 random after ack", 1'b0);
        busWr(8'h47, 32'd0);
        rdChk("R10 random pop", 8'h41, 32'd0);
      end
    end
    srcIn = '0;

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule